// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause 22 management transactions on a two-wire serial management bus. The serial clock (MDC) comes from the system clock through a programmable divider. The data line (MDIO) is bidirectional and needs an external tri-state pad, so the block brings out the output value and the output enable as separate pins and takes the pad's input value back in. A host hands over one transaction at a time: read or write, a 5-bit PHY address, a register address and, for a write, 16 bits of data. Each frame starts with a preamble of ones. The command then shifts out, most significant bit first. For a read, the block releases the line and samples the turnaround, data and trailing idle bits. For a write, the turnaround and data go out and two released clocks follow.

The request side uses a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a frame is running, `req_ready` stays low and any `req_valid` is ignored; the host must hold or re-present its request. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and `rsp_data` is valid in that cycle. A register address that does not fit in 5 bits is refused at once and causes no bus activity.

Top module: `mdio_master`

## Requirements
- R1: Out of reset `mdc` and `mdio_oe` are low, `busy` and `rsp_valid` are low, and `req_ready` is high.
- R2: Each MDC high phase and each low phase lasts `MDC_HALF` system clocks. With the default of 20 at 100 MHz, the rising edges of MDC are 400 ns apart and no phase is shorter.
- R3: Every accepted frame begins with 33 MDC clocks during which MDIO is driven to one.
- R4: A read then drives 16 command bits, MSB first: 1,1,0,1,1,0, the PHY address, then the low 5 bits of the register address.
- R5: A read then releases MDIO for 19 clocks and samples one bit per clock, s1 to s19. `rsp_data` returns s3 (bit 15) through s18 (bit 0); s1, s2 and s19 are dropped. `rsp_valid` pulses for one cycle at the end of the last clock.
- R6: A write drives 32 bits after the preamble, MSB first: 0,1,0,1, the PHY address, the register address, 1,0, then the 16 data bits. Two released clocks follow, and then `rsp_valid` pulses with `rsp_data` = 0x0000.
- R7: If the register address has any bit above bit 4 set, the request is accepted but not run. `rsp_valid` pulses in the next cycle with 0xFFFF for a read or 0x0000 for a write, and MDC and `mdio_oe` stay low.
- R8: MDIO output value and enable change only when MDC falls (or at frame start with MDC low), and stay stable for a full half period before and after each MDC rise. Read data is sampled in the last system clock of the low phase.
- R9: `req_ready` is low from acceptance until the cycle of `rsp_valid`. A `req_valid` presented while busy is not accepted and produces no frame.
- R10: `mdio_oe` is low whenever the block is idle and during every released clock. `mdio_i` passes through two flip-flops before it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_W | Register address; only values below 32 run a frame |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read result, 0xFFFF for a refused read, 0 for writes |
| busy | output | 1 | A frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO value read from the pad |

## Verification
The PHY model in the bench answers reads with a turnaround and a trailing idle bit that differ from the data bits. If the design took its result from the wrong sample window, the returned word would come out shifted by one bit. Each frame is recorded one bit per MDC rise, so a wrong clock count for the preamble, the command or the released phase shows up, and so does a flipped start or opcode bit. Register addresses above 31 must produce an immediate response with no MDC edge, which catches a design that starts a frame anyway or returns the wrong filler word. A write offered while a read is running must leave no trace, which catches a design that lets a request in while `busy` is high.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD,
    ST_REL
  } mdio_state_e;

  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 5;
  localparam int PRE_BITS    = 33;
  localparam int RD_CMD_BITS = 16;
  localparam int WR_CMD_BITS = 32;
  localparam int RD_REL_BITS = 19;
  localparam int WR_REL_BITS = 2;
  localparam int CNT_W       = 6;

  localparam logic [5:0] RD_HEAD = 6'b110110;
  localparam logic [3:0] WR_HEAD = 4'b0101;
  localparam logic [1:0] WR_TA   = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic tick_rise,
  output logic tick_fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // The cycle just before MDC goes high, and the cycle just before it goes low.
  assign tick_rise = run & ~mdc & last;
  assign tick_fall = run &  mdc & last;
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              rx_bit,
  output logic              mdio_o,
  output logic              mdio_oe
);
  mdio_state_e             st;
  logic [CNT_W-1:0]        cnt;
  logic [WR_CMD_BITS-1:0]  sh;
  logic [RD_REL_BITS-1:0]  cap;
  logic                    wr;
  logic                    reg_bad;
  logic                    take;
  logic [WR_CMD_BITS-1:0]  cmd_word;

  generate
    if (REG_W > ADDR_W) begin : g_wide
      assign reg_bad = |req_reg[REG_W-1:ADDR_W];
    end else begin : g_narrow
      assign reg_bad = 1'b0;
    end
  endgenerate

  assign busy      = (st != ST_IDLE);
  assign req_ready = ~busy;
  assign take      = req_valid & req_ready;

  always_comb begin
    if (req_write)
      cmd_word = {WR_HEAD, req_phy, req_reg[ADDR_W-1:0], WR_TA, req_wdata};
    else
      cmd_word = {RD_HEAD, req_phy, req_reg[ADDR_W-1:0], {(WR_CMD_BITS-RD_CMD_BITS){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      cap       <= '0;
      wr        <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take) begin
            if (reg_bad) begin
              rsp_valid <= 1'b1;
              rsp_data  <= req_write ? '0 : '1;
            end else begin
              st      <= ST_PRE;
              cnt     <= CNT_W'(PRE_BITS - 1);
              wr      <= req_write;
              sh      <= cmd_word;
              cap     <= '0;
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b1;
            end
          end
        end
        ST_PRE: begin
          if (tick_fall) begin
            if (cnt == '0) begin
              st     <= ST_CMD;
              cnt    <= wr ? CNT_W'(WR_CMD_BITS - 1) : CNT_W'(RD_CMD_BITS - 1);
              mdio_o <= sh[WR_CMD_BITS-1];
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_CMD: begin
          if (tick_fall) begin
            if (cnt == '0) begin
              st      <= ST_REL;
              cnt     <= wr ? CNT_W'(WR_REL_BITS - 1) : CNT_W'(RD_REL_BITS - 1);
              mdio_o  <= 1'b0;
              mdio_oe <= 1'b0;
            end else begin
              cnt    <= cnt - 1'b1;
              sh     <= {sh[WR_CMD_BITS-2:0], 1'b0};
              mdio_o <= sh[WR_CMD_BITS-2];
            end
          end
        end
        ST_REL: begin
          if (tick_rise && !wr) begin
            cap <= {cap[RD_REL_BITS-2:0], rx_bit};
          end
          if (tick_fall) begin
            if (cnt == '0) begin
              st        <= ST_IDLE;
              rsp_valid <= 1'b1;
              rsp_data  <= wr ? '0 : cap[DATA_W:1];
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int MDC_HALF    = 20,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [4:0]       req_phy,
  input  logic [REG_W-1:0] req_reg,
  input  logic [15:0]      req_wdata,
  output logic             rsp_valid,
  output logic [15:0]      rsp_data,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic tick_rise;
  logic tick_fall;
  logic rx_bit;

  mdio_clkgen #(.HALF(MDC_HALF)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mdio_i),
    .q     (rx_bit)
  );

  mdio_frame_ctl #(.REG_W(REG_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .busy      (busy),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .rx_bit    (rx_bit),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF  = 20,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [REG_W-1:0] req_reg,
  input logic             rsp_valid,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  localparam int HW = $clog2(HALF + 1) + 1;

  logic          mdc_d;
  logic [HW-1:0] hcnt;
  logic          bad_reg;
  logic          changed;

  assign bad_reg = ((req_reg >> 5) != '0);
  assign changed = (mdc != mdc_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d <= 1'b0;
      hcnt  <= HW'(HALF);
    end else begin
      mdc_d <= mdc;
      if (changed)                hcnt <= '0;
      else if (hcnt != HW'(HALF)) hcnt <= hcnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc)); // R10

  AST_MDC_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    changed |-> (hcnt >= HW'(HALF - 1))); // R2

  AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_reg) |=> (rsp_valid && !busy && !mdio_oe)); // R7

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bad_reg) |=> (busy && mdio_oe && mdio_o && !mdc)); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R9
endmodule

bind mdio_master mdio_master_chk #(.HALF(MDC_HALF), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_reg   (req_reg),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [7:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        busy;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  int   ridx = 0;
  int   per_bad = 0;
  int   sh_bad = 0;
  int   oe_rises = 0;
  bit   finished = 0;
  time  t_rise = 0;
  time  t_chg = 0;
  logic rec_o  [1:100];
  logic rec_oe [1:100];
  logic [15:0] phy_data = '0;

  // PHY answer for rise index i (1-based): s1=1, s2=0, data MSB first, s19=1
  function automatic logic phy_val(input int i);
    if (i >= 52 && i <= 67) return phy_data[67 - i];
    if (i == 51) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    if (ridx > 0 && ($time - t_rise) != 400) per_bad++;
    if (($time - t_chg) < 200) sh_bad++;
    t_rise = $time;
    ridx++;
    if (ridx <= 100) begin
      rec_o[ridx]  = mdio_o;
      rec_oe[ridx] = mdio_oe;
    end
    mdio_i <= phy_val(ridx + 1);
  end

  always @(mdio_o or mdio_oe) begin
    if (ridx > 0 && ($time - t_rise) < 200) sh_bad++;
    t_chg = $time;
  end

  always @(posedge mdio_oe) oe_rises++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit w, input logic [4:0] p, input logic [7:0] r, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output bit got, output logic [15:0] data);
    int n = 0;
    while (!rsp_valid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    got = rsp_valid;
    data = rsp_data;
    @(negedge clk);
  endtask

  task automatic start_frame(input logic [15:0] pd);
    ridx = 0; per_bad = 0; sh_bad = 0; phy_data = pd;
  endtask

  task automatic check_frame(input int bits, input logic [31:0] word, input int nb, input string tag);
    int pre_bad = 0, cmd_bad = 0, rel_bad = 0;
    logic [31:0] got_w = '0;
    for (int i = 1; i <= 33; i++) if (rec_o[i] !== 1'b1 || rec_oe[i] !== 1'b1) pre_bad++;
    chk(pre_bad == 0, "R3 preamble", pre_bad, 0);
    for (int i = 0; i < nb; i++) begin
      got_w = {got_w[30:0], rec_o[34 + i]};
      if (rec_oe[34 + i] !== 1'b1) cmd_bad++;
    end
    chk(got_w == word && cmd_bad == 0, tag, got_w, word);
    for (int i = 34 + nb; i <= bits; i++) if (rec_oe[i] !== 1'b0) rel_bad++;
    chk(rel_bad == 0, "R10 released clocks", rel_bad, 0);
    chk(ridx == bits, "R5/R6 clock count", ridx, bits);
    chk(per_bad == 0, "R2 mdc period", per_bad, 0);
    chk(sh_bad == 0, "R8 setup/hold", sh_bad, 0);
  endtask

  task automatic t_reset();
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {mdc, mdio_oe}, 0);
    chk(req_ready == 1'b1 && busy == 1'b0 && rsp_valid == 1'b0, "R1 handshake",
        {req_ready, busy, rsp_valid}, 3'b100);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [7:0] r, input logic [15:0] d);
    bit got; logic [15:0] data;
    start_frame(d);
    issue(1'b0, p, r, 16'h0);
    wait_rsp(got, data);
    chk(got, "R5 read done", got, 1);
    chk(data == d, "R5 read data", data, d);
    check_frame(68, {16'h0, 6'b110110, p, r[4:0]}, 16, "R4 read command");
  endtask

  task automatic t_write(input logic [4:0] p, input logic [7:0] r, input logic [15:0] d);
    bit got; logic [15:0] data;
    start_frame(16'h0);
    issue(1'b1, p, r, d);
    wait_rsp(got, data);
    chk(got && data == 16'h0, "R6 write done", {got, data}, 17'h10000);
    check_frame(67, {4'b0101, p, r[4:0], 2'b10, d}, 32, "R6 write command");
  endtask

  task automatic t_reject(input bit w, input logic [7:0] r);
    logic [15:0] exp = w ? 16'h0000 : 16'hFFFF;
    int oe0;
    start_frame(16'h0);
    oe0 = oe_rises;
    issue(w, 5'd3, r, 16'h1234);
    chk(rsp_valid == 1'b1 && rsp_data == exp, "R7 immediate response", {rsp_valid, rsp_data}, {1'b1, exp});
    repeat (100) @(negedge clk);
    chk(ridx == 0 && oe_rises == oe0, "R7 no bus activity", ridx, 0);
  endtask

  task automatic t_busy();
    bit got; logic [15:0] data; int oe0;
    start_frame(16'hC3A5);
    issue(1'b0, 5'd9, 8'd2, 16'h0);
    repeat (300) @(negedge clk);
    chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_reg = 8'd4; req_wdata = 16'hFFFF;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(got, data);
    chk(got && data == 16'hC3A5, "R9 running read intact", data, 16'hC3A5);
    oe0 = oe_rises;
    repeat (300) @(negedge clk);
    chk(ridx == 68 && oe_rises == oe0 && req_ready, "R9 ignored request left no frame", ridx, 68);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(5'd1, 8'd1, 16'h796D);
    t_read(5'd31, 8'd31, 16'h8001);
    t_read(5'd0, 8'd0, 16'h0000);
    t_write(5'd17, 8'd4, 16'h01E1);
    t_write(5'd10, 8'd0, 16'hA55A);
    t_reject(1'b0, 8'h20);
    t_reject(1'b1, 8'hC5);
    t_busy();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule